// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a PCI Express downstream or root port and produces the hot-plug interrupt. Software reaches both registers through one write port that carries byte-enabled 16-bit data. A select bit picks the register. Both registers are always visible on read-back outputs. Two side inputs report events from the slot: a hot insertion of function 0, and a press of the attention button. The attention-button input also serves as the path for an unplug request.

The block keeps one recorded hot-plug level. It recomputes that level in every cycle and signals only when the level changes. Signalling uses a one-cycle message pulse, tagged with the MSI-X or MSI form and a vector number, or else a level on a legacy interrupt line. The block also reports the slot's internal actions as one-cycle pulses:
- An electromechanical interlock that toggles when written.
- A command-completed event raised by every control write.
- An unplug request issued when software turns power off on an occupied slot.
- A refusal pulse when an unplug request meets an engaged interlock.

Top module: `hp_slot_ctrl`

## Requirements
- R1: A synchronous reset gives the following values. Control (ctl_rd): all enables 0; attention indicator bits [7:6] = 11 (off); power indicator bits [9:8] = 01 (on) if slot_populated is 1, else 11 (off); power control bit [10] = NOT slot_populated. Status (sta_rd): 0, except presence state bit [6] = slot_populated. Outputs: irq_level, msg_pulse, unplug_req and plug_refused are all 0.
- R2: The hot-plug level is 1 exactly when control bit [5] (interrupt enable) is 1 and, for at least one i in 0..4, both status bit i and control bit i (its enable) are 1.
- R3: Signalling happens only when the level differs from the recorded level. With msix_en or msi_en set, msg_pulse goes high for one cycle, msg_msix equals msix_en (MSI-X takes priority over MSI), and msg_vector equals irq_vector. With both enables clear, irq_level takes the new level.
- R4: In a status write, each 1 in bits [4:0] clears the matching event bit: 0 attention pressed, 1 power fault, 2 sensor changed, 3 presence changed, 4 command completed. A bit is affected only when its byte enable is set. Status bits [7:5] never change through a status write.
- R5: A control write with bit [11] = 1 and byte enable 1 set inverts interlock status bit [7]. Control bit [11] always reads 0. Control bits [10:0] take the written bytes under their byte enables.
- R6: A control write is a power-off write when it leaves bit [10] = 1 and bits [9:8] = 11, and the old value was not already in that state. A power-off write while presence bit [6] is 1 pulses unplug_req, clears bit [6] and sets bit [3].
- R7: Every control write sets command-completed status bit [4].
- R8: A card_insert pulse sets status bits [6], [3] and [0].
- R9: An attn_press while interlock status bit [7] is 1 pulses plug_refused and sets no status bit. While bit [7] is 0, it sets bit [0].
- R10: When an event is raised in the same cycle as a status write that clears that event's bit, the bit ends up set.
- R11: A message goes out only in cycles that raise an event. A status write that lowers the level sends no message. It drops irq_level only when both message enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_populated | input | 1 | Slot occupancy, sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects status |
| wr_be | input | 2 | Byte enables |
| wr_data | input | 16 | Write data |
| card_insert | input | 1 | Hot insertion of function 0 |
| attn_press | input | 1 | Attention button press or unplug request |
| msix_en | input | 1 | MSI-X enabled |
| msi_en | input | 1 | MSI enabled |
| irq_vector | input | 5 | Message vector number |
| ctl_rd | output | 16 | Slot control read-back |
| sta_rd | output | 16 | Slot status read-back |
| irq_level | output | 1 | Legacy interrupt line |
| msg_pulse | output | 1 | One-cycle message interrupt request |
| msg_msix | output | 1 | Message form: 1 MSI-X, 0 MSI |
| msg_vector | output | 5 | Vector carried by the message |
| unplug_req | output | 1 | One-cycle unplug request |
| plug_refused | output | 1 | One-cycle refusal of an unplug request |

## Verification
A status write that clears event bits can land in the same cycle as a raised event, such as a card insertion or a button press. Each can move the hot-plug level in the opposite direction. Directed steps pair an attention-button clear with a card insertion, and the random phase makes such overlaps at random. The bench judges each cycle against a model in which raised events win over clears, and in which the message decision uses the combined result, not either half alone.

// File: rtl/hp_slot_pkg.sv
// Shared bit positions, encodings and helpers for the hot-plug slot block.
// Assumes 16-bit control and status registers with two byte lanes.
package hp_slot_pkg;
    localparam int REG_W  = 16;
    localparam int EV_W   = 5;
    localparam int LANE_N = REG_W / 8;

    // control bit positions
    localparam int C_HPIE  = 5;
    localparam int C_AIND  = 6;
    localparam int C_PIND  = 8;
    localparam int C_PWR   = 10;
    localparam int C_ILOCK = 11;

    // status bit positions
    localparam int S_ABP = 0;
    localparam int S_PDC = 3;
    localparam int S_CC  = 4;
    localparam int S_PDS = 6;
    localparam int S_ILS = 7;

    localparam logic [1:0] IND_ON  = 2'b01;
    localparam logic [1:0] IND_OFF = 2'b11;

    localparam logic [REG_W-1:0] CTL_WMASK = 16'h07FF;

    // Expand byte enables into a bit mask.
    function automatic logic [REG_W-1:0] lane_mask(input logic [LANE_N-1:0] be);
        logic [REG_W-1:0] m;
        for (int i = 0; i < REG_W; i++) m[i] = be[i/8];
        return m;
    endfunction

    // Control value after reset, chosen from slot occupancy.
    function automatic logic [REG_W-1:0] ctl_reset(input logic pop);
        logic [REG_W-1:0] v;
        v = '0;
        v[C_AIND+:2] = IND_OFF;
        v[C_PIND+:2] = pop ? IND_ON : IND_OFF;
        v[C_PWR]     = ~pop;
        return v;
    endfunction
endpackage

// File: rtl/hp_ctl_reg.sv
// Slot control register: byte-enabled writes and interlock toggle request.
// It also detects the power-off write. Assumes wr is the control-write strobe.
// The interlock control bit is never stored, so it always reads 0.
module hp_ctl_reg
    import hp_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_populated,
    input  logic              wr,
    input  logic [LANE_N-1:0] be,
    input  logic [REG_W-1:0]  data,
    input  logic              pds,
    output logic [REG_W-1:0]  ctl_q,
    output logic [REG_W-1:0]  ctl_nxt,
    output logic              ilock_tog,
    output logic              pwr_off_hit
);
    logic [REG_W-1:0] m;
    logic [REG_W-1:0] merged;
    logic             was_off;
    logic             now_off;

    // Merge write data and derive the side actions of this write.
    always_comb begin
        m           = lane_mask(be);
        merged      = (ctl_q & ~(CTL_WMASK & m)) | (data & CTL_WMASK & m);
        ctl_nxt     = wr ? merged : ctl_q;
        ilock_tog   = wr && m[C_ILOCK] && data[C_ILOCK];
        was_off     = ctl_q[C_PWR] && (ctl_q[C_PIND+:2] == IND_OFF);
        now_off     = merged[C_PWR] && (merged[C_PIND+:2] == IND_OFF);
        pwr_off_hit = wr && pds && now_off && !was_off;
    end

    // Register update with occupancy-dependent reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= ctl_reset(slot_populated);
        else        ctl_q <= ctl_nxt;
    end
endmodule

// File: rtl/hp_sta_reg.sv
// Slot status register: clears events written with 1, sets raised events,
// toggles the interlock and updates presence. A raised event wins over a
// clear in the same cycle. Status writes never touch bits [7:5].
module hp_sta_reg
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_populated,
    input  logic [EV_W-1:0]  ev_set,
    input  logic [EV_W-1:0]  ev_clr,
    input  logic             ilock_tog,
    input  logic             pds_set,
    input  logic             pds_clr,
    output logic [REG_W-1:0] sta_q,
    output logic [REG_W-1:0] sta_nxt
);
    logic [EV_W-1:0] ev_nxt;

    // One clear-then-set cell per event bit.
    for (genvar i = 0; i < EV_W; i++) begin : g_ev
        assign ev_nxt[i] = ev_set[i] | (sta_q[i] & ~ev_clr[i]);
    end

    // Assemble the next status word.
    always_comb begin
        sta_nxt           = sta_q;
        sta_nxt[EV_W-1:0] = ev_nxt;
        sta_nxt[S_ILS]    = sta_q[S_ILS] ^ ilock_tog;
        if (pds_set)      sta_nxt[S_PDS] = 1'b1;
        else if (pds_clr) sta_nxt[S_PDS] = 1'b0;
    end

    // Register update; presence reloads from occupancy on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q        <= '0;
            sta_q[S_PDS] <= slot_populated;
        end else begin
            sta_q <= sta_nxt;
        end
    end
endmodule

// File: rtl/hp_notify.sv
// Hot-plug level tracking and interrupt delivery. Works from next-state
// register values, so outputs line up with the register update. A message
// fires only in raise cycles and only on a level change. The legacy line
// follows level changes while both message enables are clear.
module hp_notify
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ctl_nxt,
    input  logic [REG_W-1:0] sta_nxt,
    input  logic             raise,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] vec,
    output logic             irq_level,
    output logic             msg_pulse,
    output logic             msg_msix,
    output logic [VEC_W-1:0] msg_vec
);
    logic lvl_q;
    logic lvl_nxt;
    logic chg;
    logic msg_mode;
    logic send;

    // Combined level and the delivery decision.
    always_comb begin
        lvl_nxt  = ctl_nxt[C_HPIE] && |(sta_nxt[EV_W-1:0] & ctl_nxt[EV_W-1:0]);
        chg      = lvl_nxt != lvl_q;
        msg_mode = msix_en || msi_en;
        send     = chg && msg_mode && raise;
    end

    // Record level and drive the interrupt outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q     <= 1'b0;
            irq_level <= 1'b0;
            msg_pulse <= 1'b0;
            msg_msix  <= 1'b0;
            msg_vec   <= '0;
        end else begin
            lvl_q     <= lvl_nxt;
            msg_pulse <= send;
            if (send) begin
                msg_msix <= msix_en;
                msg_vec  <= vec;
            end
            if (chg && !msg_mode) irq_level <= lvl_nxt;
        end
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
// Top of the hot-plug slot register controller. Routes the write port to
// the control and status registers and gathers raised events. Rejects
// unplug requests against an engaged interlock. Assumes single-cycle
// pulses on card_insert and attn_press.
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_populated,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [LANE_N-1:0] wr_be,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              card_insert,
    input  logic              attn_press,
    input  logic              msix_en,
    input  logic              msi_en,
    input  logic [VEC_W-1:0]  irq_vector,
    output logic [REG_W-1:0]  ctl_rd,
    output logic [REG_W-1:0]  sta_rd,
    output logic              irq_level,
    output logic              msg_pulse,
    output logic              msg_msix,
    output logic [VEC_W-1:0]  msg_vector,
    output logic              unplug_req,
    output logic              plug_refused
);
    logic             ctl_wr;
    logic             sta_wr;
    logic [REG_W-1:0] ctl_q, ctl_nxt, sta_q, sta_nxt;
    logic             ilock_tog, pwr_off_hit;
    logic             btn_ok, btn_no;
    logic [EV_W-1:0]  ev_set, ev_clr;

    // Decode the write target and collect this cycle's raised events.
    always_comb begin
        ctl_wr = wr_en && !wr_sel;
        sta_wr = wr_en && wr_sel;
        btn_ok = attn_press && !sta_q[S_ILS];
        btn_no = attn_press && sta_q[S_ILS];
        ev_set = '0;
        if (ctl_wr)      ev_set[S_CC]  = 1'b1;
        if (pwr_off_hit) ev_set[S_PDC] = 1'b1;
        if (card_insert) begin
            ev_set[S_PDC] = 1'b1;
            ev_set[S_ABP] = 1'b1;
        end
        if (btn_ok)      ev_set[S_ABP] = 1'b1;
        ev_clr = sta_wr ? (wr_data[EV_W-1:0] & lane_mask(wr_be)[EV_W-1:0]) : '0;
    end

    hp_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .slot_populated(slot_populated),
        .wr(ctl_wr), .be(wr_be), .data(wr_data), .pds(sta_q[S_PDS]),
        .ctl_q(ctl_q), .ctl_nxt(ctl_nxt),
        .ilock_tog(ilock_tog), .pwr_off_hit(pwr_off_hit)
    );

    hp_sta_reg u_sta (
        .clk(clk), .rst_n(rst_n), .slot_populated(slot_populated),
        .ev_set(ev_set), .ev_clr(ev_clr), .ilock_tog(ilock_tog),
        .pds_set(card_insert), .pds_clr(pwr_off_hit),
        .sta_q(sta_q), .sta_nxt(sta_nxt)
    );

    hp_notify #(.VEC_W(VEC_W)) u_ntf (
        .clk(clk), .rst_n(rst_n), .ctl_nxt(ctl_nxt), .sta_nxt(sta_nxt),
        .raise(|ev_set), .msix_en(msix_en), .msi_en(msi_en), .vec(irq_vector),
        .irq_level(irq_level), .msg_pulse(msg_pulse),
        .msg_msix(msg_msix), .msg_vec(msg_vector)
    );

    // Register the one-cycle action pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unplug_req   <= 1'b0;
            plug_refused <= 1'b0;
        end else begin
            unplug_req   <= pwr_off_hit;
            plug_refused <= btn_no;
        end
    end

    assign ctl_rd = ctl_q;
    assign sta_rd = sta_q;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
// Property checker for hp_slot_ctrl, attached by bind. Observes ports only.
module hp_slot_ctrl_chk #(
    parameter int VEC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [1:0]       wr_be,
    input logic [15:0]      wr_data,
    input logic             card_insert,
    input logic             attn_press,
    input logic             msix_en,
    input logic             msi_en,
    input logic [15:0]      ctl_rd,
    input logic [15:0]      sta_rd,
    input logic             msg_pulse,
    input logic             unplug_req,
    input logic             plug_refused
);
    // R1
    rst_attn_off_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl_rd[7:6] == 2'b11) && (sta_rd[4:0] == 5'd0) && !msg_pulse);

    // R7
    cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> sta_rd[4]);

    // R5
    ilock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_be[1] && wr_data[11]) |=> (sta_rd[7] != $past(sta_rd[7])));

    // R5
    ilock_ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_be[1] && wr_data[11]) |=> !ctl_rd[11]);

    // R8
    insert_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_insert |=> (sta_rd[6] && sta_rd[3] && sta_rd[0]));

    // R6
    unplug_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unplug_req |-> (!sta_rd[6] && sta_rd[3]));

    // R9
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attn_press && sta_rd[7] && !(wr_en && !wr_sel)) |=> plug_refused);

    // R3
    msg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |-> $past(msix_en || msi_en));

    // R11
    msg_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |-> $past((wr_en && !wr_sel) || card_insert || attn_press));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .card_insert(card_insert), .attn_press(attn_press),
    .msix_en(msix_en), .msi_en(msi_en), .ctl_rd(ctl_rd), .sta_rd(sta_rd),
    .msg_pulse(msg_pulse), .unplug_req(unplug_req), .plug_refused(plug_refused)
);

// File: tb/hp_slot_ctrl_tb_top.sv
// Bench for hp_slot_ctrl: directed corner cases, then seeded random traffic.
// Every cycle is compared with a requirement-level model.
module hp_slot_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_populated = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = '0;
    logic        card_insert = 1'b0, attn_press = 1'b0;
    logic        msix_en = 1'b0, msi_en = 1'b0;
    logic [4:0]  irq_vector = '0;
    logic [15:0] ctl_rd, sta_rd;
    logic        irq_level, msg_pulse, msg_msix, unplug_req, plug_refused;
    logic [4:0]  msg_vector;

    int n_run = 0, n_fail = 0, cyc = 0;

    // model state
    logic [15:0] mc, ms;
    logic        mlvl, mirq, mmsg, mmsix, munp, mref;
    logic [4:0]  mvec;

    always #10 clk = ~clk;

    hp_slot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .slot_populated(slot_populated),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be), .wr_data(wr_data),
        .card_insert(card_insert), .attn_press(attn_press),
        .msix_en(msix_en), .msi_en(msi_en), .irq_vector(irq_vector),
        .ctl_rd(ctl_rd), .sta_rd(sta_rd), .irq_level(irq_level),
        .msg_pulse(msg_pulse), .msg_msix(msg_msix), .msg_vector(msg_vector),
        .unplug_req(unplug_req), .plug_refused(plug_refused)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    function automatic logic [15:0] bmask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // Advance the model by one clocked cycle using the driven inputs.
    task automatic model_step();
        logic [15:0] nc, m, clr;
        logic [4:0]  ev;
        logic        tog, poff, lvl_n;
        m = bmask(wr_be); ev = '0; tog = 0; poff = 0; clr = '0;
        mref = attn_press && ms[7];
        if (wr_en && !wr_sel) begin
            nc   = (mc & ~(16'h07FF & m)) | (wr_data & 16'h07FF & m);
            tog  = wr_data[11] && wr_be[1];
            poff = ms[6] && nc[10] && nc[9:8] == 2'b11 && !(mc[10] && mc[9:8] == 2'b11);
            mc   = nc;
            ev[4] = 1'b1;
            if (poff) ev[3] = 1'b1;
        end
        if (wr_en && wr_sel) clr = wr_data & m & 16'h001F;
        if (attn_press && !ms[7]) ev[0] = 1'b1;
        if (card_insert) begin ev[0] = 1'b1; ev[3] = 1'b1; end
        ms[4:0] = (ms[4:0] & ~clr[4:0]) | ev;
        ms[7]   = ms[7] ^ tog;
        if (card_insert) ms[6] = 1'b1; else if (poff) ms[6] = 1'b0;
        lvl_n = mc[5] && |(ms[4:0] & mc[4:0]);
        mmsg  = (lvl_n != mlvl) && (msix_en || msi_en) && (ev != 0);
        if (mmsg) begin mmsix = msix_en; mvec = irq_vector; end
        if ((lvl_n != mlvl) && !msix_en && !msi_en) mirq = lvl_n;
        mlvl = lvl_n;
        munp = poff;
    endtask

    task automatic check_all();
        chk("R5 ctl", ctl_rd, mc);
        chk("R4 sta", sta_rd, ms);
        chk("R3 irq_level", {15'd0, irq_level}, {15'd0, mirq});
        chk("R11 msg_pulse", {15'd0, msg_pulse}, {15'd0, mmsg});
        if (mmsg) begin
            chk("R3 msg_msix", {15'd0, msg_msix}, {15'd0, mmsix});
            chk("R3 msg_vector", {11'd0, msg_vector}, {11'd0, mvec});
        end
        chk("R6 unplug_req", {15'd0, unplug_req}, {15'd0, munp});
        chk("R9 plug_refused", {15'd0, plug_refused}, {15'd0, mref});
    endtask

    // Drive one cycle at the falling edge, model it, check after the rise.
    task automatic step(input logic w, input logic sel, input logic [1:0] be,
                        input logic [15:0] d, input logic ins, input logic btn);
        @(negedge clk);
        wr_en = w; wr_sel = sel; wr_be = be; wr_data = d;
        card_insert = ins; attn_press = btn;
        @(posedge clk);
        model_step();
        #5;
        check_all();
    endtask

    task automatic do_reset(input logic pop);
        @(negedge clk);
        rst_n = 1'b0; slot_populated = pop;
        wr_en = 0; card_insert = 0; attn_press = 0;
        @(posedge clk);
        mc = 16'h0000; mc[7:6] = 2'b11; mc[9:8] = pop ? 2'b01 : 2'b11; mc[10] = ~pop;
        ms = '0; ms[6] = pop;
        mlvl = 0; mirq = 0; mmsg = 0; munp = 0; mref = 0; mmsix = 0; mvec = '0;
        #5;
        check_all();
        chk("R1 ctl reset", ctl_rd, pop ? 16'h01C0 : 16'h07C0);
        chk("R1 sta reset", sta_rd, pop ? 16'h0040 : 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset(1'b0);
        do_reset(1'b1);
        // R7: control write enabling the interrupt and the button event
        step(1, 0, 2'b11, 16'h01E1, 0, 0);
        chk("R7 cc set", {15'd0, sta_rd[4]}, 16'd1);
        // R2: button press raises the level on the legacy line
        step(0, 0, 2'b00, 16'h0, 0, 1);
        chk("R2 level up", {15'd0, irq_level}, 16'd1);
        // R3: pressing again with the bit set gives no message
        msi_en = 1'b1;
        step(0, 0, 2'b00, 16'h0, 0, 1);
        chk("R3 no repeat", {15'd0, msg_pulse}, 16'd0);
        // R10: clear of bit 0 in the same cycle as an insertion
        step(1, 1, 2'b11, 16'h0001, 1, 0);
        chk("R10 raise wins", {15'd0, sta_rd[0]}, 16'd1);
        chk("R8 insert", {13'd0, sta_rd[6], sta_rd[3], sta_rd[0]}, 16'd7);
        // R11: clearing lowers the level without any message
        step(1, 1, 2'b01, 16'h001F, 0, 0);
        chk("R11 silent clear", {15'd0, msg_pulse}, 16'd0);
        // R3: with MSI-X enabled a new rise sends an MSI-X message
        msix_en = 1'b1; irq_vector = 5'd19;
        step(0, 0, 2'b00, 16'h0, 0, 1);
        chk("R3 msix msg", {14'd0, msg_pulse, msg_msix}, 16'd3);
        chk("R3 vector", {11'd0, msg_vector}, 16'd19);
        // R5: interlock toggle; R9: a button press is then refused
        step(1, 0, 2'b10, 16'h0800, 0, 0);
        chk("R5 ilock on", {15'd0, sta_rd[7]}, 16'd1);
        chk("R5 ctl bit zero", {15'd0, ctl_rd[11]}, 16'd0);
        step(1, 1, 2'b01, 16'h0001, 0, 0);
        step(0, 0, 2'b00, 16'h0, 0, 1);
        chk("R9 refused", {15'd0, plug_refused}, 16'd1);
        chk("R9 no abp", {15'd0, sta_rd[0]}, 16'd0);
        // R6: power off with the card present
        step(1, 0, 2'b11, 16'h07E1, 0, 0);
        chk("R6 unplug", {13'd0, unplug_req, sta_rd[6], sta_rd[3]}, 16'd5);
        // random phase
        msix_en = 0; msi_en = 0;
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            logic [2:0]  op;
            op = 3'($urandom_range(0, 7));
            msix_en = ($urandom_range(0, 7) == 0);
            msi_en  = ($urandom_range(0, 3) == 0);
            irq_vector = 5'($urandom);
            d = 16'($urandom);
            if (op[0]) d[5] = 1'b1;
            case (op)
                3'd0, 3'd1: step(1, 0, 2'($urandom_range(1, 3)), d, 0, 0);
                3'd2, 3'd3: step(1, 1, 2'($urandom_range(0, 3)), d, $urandom_range(0, 3) == 0,
                                 $urandom_range(0, 3) == 0);
                3'd4:       step(0, 0, 2'b00, d, 1, $urandom_range(0, 1) == 0);
                3'd5:       step(0, 0, 2'b00, d, 0, 1);
                default:    step(0, 0, 2'b00, d, 0, 0);
            endcase
            if ((i % 500) == 499) do_reset(i[9]);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule